// File: doc/BRIEF.md
# Two-Bank SDRAM Command Decoder and Bank Tracker

This block sits on the device side of a two-bank synchronous DRAM and interprets the command pins on every rising clock edge. It turns chip select, the three strobes, the bank-select bit, the auto-deactivate address bit and the address into one of twelve commands. It keeps an active/idle flag and the open row for each bank, and it holds the mode register that sets the burst length. Commands that the current bank state forbids are reported on a one-cycle illegal pulse and leave the state alone.

A read or write entered with the auto-deactivate bit high closes its bank on its own once the burst has run for the programmed length, which is 4 or 8 cycles. A burst-stop ends the running burst early. The bank tracker outputs let a memory model or a protocol monitor follow which rows are open without decoding the pins again.

All outputs are registered. The values seen after a clock edge describe the command sampled on that edge and the state that results from it.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After each edge `cmd_o` holds the code of the command sampled on that edge: 0 mode set, 1 single-bank deactivate, 2 deactivate-all, 3 activate, 4 write, 5 write with auto-deactivate, 6 read, 7 read with auto-deactivate, 8 burst stop, 9 no-op, 10 deselect, 11 auto-refresh. The strobes (ras_n, cas_n, we_n) decode as 000 mode set, 001 refresh, 010 deactivate, 011 activate, 100 write, 101 read, 110 stop, 111 no-op.
- R2: With `cs_n` high the command is deselect (10), whatever the strobes carry, and no bank opens or closes because of that cycle's strobes.
- R3: An activate to an idle bank sets that bank's active flag and stores `addr` as its open row. `bank_sel` high names bank 1 (top), low names bank 0 (bottom). Bank i's row is `open_row_o[i*11 +: 11]` and its flag is `bank_active_o[i]`.
- R4: An activate to an already active bank raises `illegal_o` for one cycle and changes neither the flag nor the row.
- R5: The deactivate encoding with address bit 10 low closes only the bank named by `bank_sel`. With bit 10 high it closes both banks.
- R6: A read or write to an idle bank raises `illegal_o` and leaves the bank state unchanged.
- R7: A read or write entered with address bit 10 high closes its bank on the edge that comes burst-length edges after the entry edge. Without the bit, the bank stays open.
- R8: The burst length used by R7 is 4 when mode bits [2:0] are 010 and 8 when they are 011.
- R9: A mode set with both banks idle loads `addr[9:0]` into `mode_o` only when bits [8:7] are 00, bits [6:4] are 010, bit 3 is 0 and bits [2:0] are 010 or 011. Any other word leaves `mode_o` unchanged. Bit 9 is stored as given. Nothing other than a mode set changes `mode_o`.
- R10: A mode set or an auto-refresh while any bank is active raises `illegal_o` and changes nothing. An accepted refresh leaves both banks idle.
- R11: Deselect cycles do not disturb a running burst: its auto-deactivate still happens on schedule.
- R12: A burst stop ends the running burst. If that burst carried auto-deactivate, its bank closes on the stop edge. Otherwise the bank stays open.
- R13: During and just after reset, both banks are idle, both rows are 0, `mode_o` is 0x022, `cmd_o` is 9 and `illegal_o` is 0.
- R14: A read or write entered while an auto-deactivating burst is still running raises `illegal_o` and leaves the bank state unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, low enables strobe decoding |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| bank_sel | input | 1 | Bank select, 1 = bank 1 (top), 0 = bank 0 (bottom) |
| addr | input | 11 | Address; bit 10 is the auto-deactivate / all-bank flag |
| cmd_o | output | 4 | Decoded command code of the last sampled edge |
| illegal_o | output | 1 | One-cycle pulse for a command illegal in the bank state |
| bank_active_o | output | 2 | Per-bank active flag |
| open_row_o | output | 22 | Per-bank open row, bank i at [i*11 +: 11] |
| mode_o | output | 10 | Mode register contents |

## Verification
The hardest situation to reach is a burst whose auto-deactivate is still pending while other commands arrive: a stop, a second access, deselect cycles, or a deactivate of the same bank. The stimulus opens both banks, starts an auto-deactivating burst, and then places the competing command a known number of edges after the entry edge. The check then counts edges to the exact cycle in which the bank flag should fall. The 8-beat case is only reachable after a valid mode word has been written, so the same sequence is repeated after reprogramming.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

   typedef enum logic [3:0] {
      CMD_MODE_SET  = 4'd0,
      CMD_CLOSE_ONE = 4'd1,
      CMD_CLOSE_ALL = 4'd2,
      CMD_OPEN_ROW  = 4'd3,
      CMD_WRITE     = 4'd4,
      CMD_WRITE_AC  = 4'd5,
      CMD_READ      = 4'd6,
      CMD_READ_AC   = 4'd7,
      CMD_HALT      = 4'd8,
      CMD_IDLE      = 4'd9,
      CMD_UNSEL     = 4'd10,
      CMD_REFRESH   = 4'd11
   } sdc_cmd_e;

   function automatic logic is_access(input sdc_cmd_e c);
      return (c == CMD_WRITE) || (c == CMD_WRITE_AC) ||
             (c == CMD_READ)  || (c == CMD_READ_AC);
   endfunction

   function automatic logic is_autoclose(input sdc_cmd_e c);
      return (c == CMD_WRITE_AC) || (c == CMD_READ_AC);
   endfunction

endpackage

// File: rtl/sdc_decode.sv
module sdc_decode
   import sdc_pkg::*;
(
   input  logic     cs_n,
   input  logic     ras_n,
   input  logic     cas_n,
   input  logic     we_n,
   input  logic     flag_a10,
   output sdc_cmd_e cmd
);
   always_comb begin
      if (cs_n) begin
         cmd = CMD_UNSEL;
      end else begin
         unique case ({ras_n, cas_n, we_n})
            3'b000:  cmd = CMD_MODE_SET;
            3'b001:  cmd = CMD_REFRESH;
            3'b010:  cmd = flag_a10 ? CMD_CLOSE_ALL : CMD_CLOSE_ONE;
            3'b011:  cmd = CMD_OPEN_ROW;
            3'b100:  cmd = flag_a10 ? CMD_WRITE_AC : CMD_WRITE;
            3'b101:  cmd = flag_a10 ? CMD_READ_AC : CMD_READ;
            3'b110:  cmd = CMD_HALT;
            default: cmd = CMD_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/sdc_mode_reg.sv
module sdc_mode_reg #(
   parameter int          MODE_W   = 10,
   parameter logic [2:0]  LAT_CODE = 3'b010,
   parameter logic [2:0]  LEN4     = 3'b010,
   parameter logic [2:0]  LEN8     = 3'b011
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [MODE_W-1:0] wr_word,
   output logic [MODE_W-1:0] mode_q,
   output logic              long_burst
);
   localparam logic [MODE_W-1:0] RESET_WORD =
      MODE_W'({LAT_CODE, 1'b0, LEN4});

   logic word_ok;

   always_comb begin
      word_ok = (wr_word[8:7] == 2'b00) &&
                (wr_word[6:4] == LAT_CODE) &&
                (wr_word[3] == 1'b0) &&
                ((wr_word[2:0] == LEN4) || (wr_word[2:0] == LEN8));
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                mode_q <= RESET_WORD;
      else if (wr_en && word_ok) mode_q <= wr_word;
   end

   assign long_burst = (mode_q[2:0] == LEN8);
endmodule

// File: rtl/sdc_burst.sv
module sdc_burst #(
   parameter int NBANK = 2,
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             start_ac,
   input  logic             start_bank,
   input  logic [CNT_W-1:0] len_m1,
   input  logic             halt,
   input  logic [NBANK-1:0] cancel_vec,
   output logic             busy,
   output logic             ac_pend,
   output logic [NBANK-1:0] auto_close
);
   logic [CNT_W-1:0] cnt_q;
   logic             ac_bank_q;
   logic             last_beat;
   logic             cancelled;

   assign last_beat = busy && (cnt_q == '0);
   assign cancelled = ac_pend && cancel_vec[ac_bank_q];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         ac_pend   <= 1'b0;
         cnt_q     <= '0;
         ac_bank_q <= 1'b0;
      end else if (start) begin
         busy      <= 1'b1;
         ac_pend   <= start_ac;
         cnt_q     <= len_m1;
         ac_bank_q <= start_bank;
      end else if (halt || last_beat) begin
         busy    <= 1'b0;
         ac_pend <= 1'b0;
      end else begin
         if (busy)      cnt_q   <= cnt_q - 1'b1;
         if (cancelled) ac_pend <= 1'b0;
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_close
      assign auto_close[b] = ac_pend && !cancelled && (ac_bank_q == 1'(b)) &&
                             !start && (halt || last_beat);
   end
endmodule

// File: rtl/sdc_bank.sv
module sdc_bank #(
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_en,
   input  logic             close_en,
   input  logic [ROW_W-1:0] row_in,
   output logic             active,
   output logic [ROW_W-1:0] row_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active <= 1'b0;
         row_q  <= '0;
      end else if (close_en) begin
         active <= 1'b0;
      end else if (open_en) begin
         active <= 1'b1;
         row_q  <= row_in;
      end
   end
endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
   import sdc_pkg::*;
#(
   parameter int         ADDR_W   = 11,
   parameter int         AC_BIT   = 10,
   parameter int         MODE_W   = 10,
   parameter int         NBANK    = 2,
   parameter logic [2:0] LAT_CODE = 3'b010,
   parameter logic [2:0] LEN4     = 3'b010,
   parameter logic [2:0] LEN8     = 3'b011
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    cs_n,
   input  logic                    ras_n,
   input  logic                    cas_n,
   input  logic                    we_n,
   input  logic                    bank_sel,
   input  logic [ADDR_W-1:0]       addr,
   output logic [3:0]              cmd_o,
   output logic                    illegal_o,
   output logic [NBANK-1:0]        bank_active_o,
   output logic [NBANK*ADDR_W-1:0] open_row_o,
   output logic [MODE_W-1:0]       mode_o
);
   localparam int CNT_W = 3;

   if (NBANK != 2) begin : g_bad_nbank
      $error("sdram_cmd_tracker: one bank-select bit needs NBANK == 2");
   end
   if (AC_BIT >= ADDR_W) begin : g_bad_acbit
      $error("sdram_cmd_tracker: AC_BIT must lie inside the address");
   end
   if (MODE_W < 9 || MODE_W > ADDR_W) begin : g_bad_mode
      $error("sdram_cmd_tracker: MODE_W must cover the fields and fit the address");
   end

   sdc_cmd_e         cmd;
   logic             refused;
   logic             long_burst;
   logic             busy, ac_pend;
   logic [NBANK-1:0] auto_close;
   logic [NBANK-1:0] deac_vec;
   logic [NBANK-1:0] open_vec;
   logic             mode_wr;
   logic             acc_start;

   sdc_decode u_dec (
      .cs_n     (cs_n),
      .ras_n    (ras_n),
      .cas_n    (cas_n),
      .we_n     (we_n),
      .flag_a10 (addr[AC_BIT]),
      .cmd      (cmd)
   );

   always_comb begin
      refused = 1'b0;
      if (cmd == CMD_OPEN_ROW)
         refused = bank_active_o[bank_sel];
      else if (is_access(cmd))
         refused = !bank_active_o[bank_sel] || ac_pend;
      else if (cmd == CMD_MODE_SET || cmd == CMD_REFRESH)
         refused = |bank_active_o;
   end

   assign acc_start = is_access(cmd) && !refused;
   assign mode_wr   = (cmd == CMD_MODE_SET) && !refused;

   for (genvar b = 0; b < NBANK; b++) begin : g_bank_ctl
      assign deac_vec[b] = (cmd == CMD_CLOSE_ALL) ||
                           ((cmd == CMD_CLOSE_ONE) && (bank_sel == 1'(b)));
      assign open_vec[b] = (cmd == CMD_OPEN_ROW) && !refused &&
                           (bank_sel == 1'(b));

      sdc_bank #(.ROW_W(ADDR_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .open_en  (open_vec[b]),
         .close_en (deac_vec[b] | auto_close[b]),
         .row_in   (addr),
         .active   (bank_active_o[b]),
         .row_q    (open_row_o[b*ADDR_W +: ADDR_W])
      );
   end

   sdc_burst #(.NBANK(NBANK), .CNT_W(CNT_W)) u_burst (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (acc_start),
      .start_ac   (is_autoclose(cmd)),
      .start_bank (bank_sel),
      .len_m1     (long_burst ? CNT_W'(7) : CNT_W'(3)),
      .halt       (cmd == CMD_HALT),
      .cancel_vec (deac_vec),
      .busy       (busy),
      .ac_pend    (ac_pend),
      .auto_close (auto_close)
   );

   sdc_mode_reg #(
      .MODE_W   (MODE_W),
      .LAT_CODE (LAT_CODE),
      .LEN4     (LEN4),
      .LEN8     (LEN8)
   ) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (mode_wr),
      .wr_word    (addr[MODE_W-1:0]),
      .mode_q     (mode_o),
      .long_burst (long_burst)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_o     <= CMD_IDLE;
         illegal_o <= 1'b0;
      end else begin
         cmd_o     <= cmd;
         illegal_o <= refused;
      end
   end
endmodule

// File: rtl/sdram_cmd_tracker_chk.sv
module sdram_cmd_tracker_chk #(
   parameter int ADDR_W = 11,
   parameter int MODE_W = 10,
   parameter int NBANK  = 2
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic [3:0]              cmd_o,
   input logic                    illegal_o,
   input logic [NBANK-1:0]        bank_active_o,
   input logic [NBANK*ADDR_W-1:0] open_row_o,
   input logic [MODE_W-1:0]       mode_o
);
   // R2: a deselect cycle never opens a bank
   a_r2_unsel_no_open: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 4'd10) |-> ((bank_active_o & ~$past(bank_active_o)) == '0));

   // R3: an accepted activate raises one active flag
   a_r3_open_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 4'd3 && !illegal_o) |-> ((bank_active_o & ~$past(bank_active_o)) != '0));

   // R4 / R6: a refused command leaves the open rows alone
   a_r4_refused_keeps_rows: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (open_row_o == $past(open_row_o)));

   // R5: deactivate-all leaves both banks idle
   a_r5_close_all_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 4'd2) |-> (bank_active_o == '0));

   // R9: only an accepted mode set changes the mode register
   a_r9_mode_only_by_set: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_o != $past(mode_o)) |-> (cmd_o == 4'd0 && !illegal_o));

   // R10: an accepted refresh happens with both banks idle
   a_r10_refresh_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_o == 4'd11 && !illegal_o) |-> (bank_active_o == '0));

   // R10: mode set or refresh refused while a bank is open
   a_r10_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
      ((cmd_o == 4'd0 || cmd_o == 4'd11) && $past(bank_active_o) != '0) |-> illegal_o);
endmodule

bind sdram_cmd_tracker sdram_cmd_tracker_chk #(
   .ADDR_W (ADDR_W),
   .MODE_W (MODE_W),
   .NBANK  (NBANK)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .cmd_o         (cmd_o),
   .illegal_o     (illegal_o),
   .bank_active_o (bank_active_o),
   .open_row_o    (open_row_o),
   .mode_o        (mode_o)
);

// File: tb/sim_sdram_cmd_tracker.sv
module sim_sdram_cmd_tracker;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic        bank_sel = 1'b0;
   logic [10:0] addr = '0;
   logic [3:0]  cmd_o;
   logic        illegal_o;
   logic [1:0]  bank_active_o;
   logic [21:0] open_row_o;
   logic [9:0]  mode_o;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   sdram_cmd_tracker u0 (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .bank_sel(bank_sel), .addr(addr), .cmd_o(cmd_o),
      .illegal_o(illegal_o), .bank_active_o(bank_active_o),
      .open_row_o(open_row_o), .mode_o(mode_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // drive one command for one edge, then return to no-op
   task automatic step(input logic c, input logic r, input logic ca, input logic w,
                       input logic b, input logic [10:0] a);
      cs_n = c; ras_n = r; cas_n = ca; we_n = w; bank_sel = b; addr = a;
      @(posedge clk);
      @(negedge clk);
      cs_n = 1'b0; ras_n = 1'b1; cas_n = 1'b1; we_n = 1'b1; bank_sel = 1'b0; addr = '0;
   endtask

   task automatic nop(input int n);
      for (int i = 0; i < n; i++) step(0, 1, 1, 1, 0, '0);
   endtask
   task automatic c_open(input logic b, input logic [10:0] row); step(0, 0, 1, 1, b, row); endtask
   task automatic c_read(input logic b, input logic ac); step(0, 1, 0, 1, b, {ac, 10'h004}); endtask
   task automatic c_write(input logic b, input logic ac); step(0, 1, 0, 0, b, {ac, 10'h008}); endtask
   task automatic c_close(input logic b, input logic all); step(0, 0, 1, 0, b, {all, 10'h000}); endtask
   task automatic c_mode(input logic [9:0] w); step(0, 0, 0, 0, 0, {1'b0, w}); endtask
   task automatic c_refresh(); step(0, 0, 0, 1, 1, 11'h7FF); endtask
   task automatic c_halt(); step(0, 1, 1, 0, 0, '0); endtask

   function automatic logic [10:0] row_of(input int b);
      return open_row_o[b*11 +: 11];
   endfunction

   task automatic t_reset();
      chk("R13 active", bank_active_o, 2'b00);
      chk("R13 rows", open_row_o, 22'h0);
      chk("R13 mode", mode_o, 10'h022);
      chk("R13 cmd", cmd_o, 4'd9);
      chk("R13 illegal", illegal_o, 1'b0);
   endtask

   task automatic t_open_close();
      c_open(1, 11'h5A3);
      chk("R1 activate code", cmd_o, 4'd3);
      chk("R3 top active", bank_active_o, 2'b10);
      chk("R3 top row", row_of(1), 11'h5A3);
      c_open(0, 11'h0F1);
      chk("R3 both active", bank_active_o, 2'b11);
      chk("R3 bottom row", row_of(0), 11'h0F1);
      c_open(1, 11'h111);
      chk("R4 reopen illegal", illegal_o, 1'b1);
      chk("R4 row kept", row_of(1), 11'h5A3);
      nop(1);
      chk("R4 pulse ends", illegal_o, 1'b0);
      c_close(1, 0);
      chk("R5 single close code", cmd_o, 4'd1);
      chk("R5 single close", bank_active_o, 2'b01);
      c_open(1, 11'h222);
      c_close(0, 1);
      chk("R5 close all code", cmd_o, 4'd2);
      chk("R5 close all", bank_active_o, 2'b00);
   endtask

   task automatic t_closed_access();
      c_read(0, 0);
      chk("R1 read code", cmd_o, 4'd6);
      chk("R6 read closed illegal", illegal_o, 1'b1);
      chk("R6 state kept", bank_active_o, 2'b00);
      c_write(1, 1);
      chk("R1 write-ac code", cmd_o, 4'd5);
      chk("R6 write closed illegal", illegal_o, 1'b1);
   endtask

   task automatic t_autoclose4();
      c_open(0, 11'h033);
      c_read(0, 1);
      chk("R1 read-ac code", cmd_o, 4'd7);
      nop(3);
      chk("R7 open before end", bank_active_o, 2'b01);
      nop(1);
      chk("R7 closed after 4", bank_active_o, 2'b00);
      c_open(1, 11'h044);
      c_write(1, 0);
      chk("R1 write code", cmd_o, 4'd4);
      nop(5);
      chk("R7 plain write stays open", bank_active_o, 2'b10);
      c_close(1, 0);
   endtask

   task automatic t_mode();
      c_open(0, 11'h001);
      c_mode(10'h023);
      chk("R10 mode set illegal", illegal_o, 1'b1);
      chk("R10 mode kept", mode_o, 10'h022);
      c_refresh();
      chk("R10 refresh illegal", illegal_o, 1'b1);
      chk("R10 bank kept", bank_active_o, 2'b01);
      c_close(0, 1);
      c_refresh();
      chk("R1 refresh code", cmd_o, 4'd11);
      chk("R10 refresh ok", illegal_o, 1'b0);
      chk("R10 refresh idle", bank_active_o, 2'b00);
      c_mode(10'h032);
      chk("R1 mode code", cmd_o, 4'd0);
      chk("R9 bad latency ignored", mode_o, 10'h022);
      c_mode(10'h02A);
      chk("R9 bad type ignored", mode_o, 10'h022);
      c_mode(10'h122);
      chk("R9 bad bit8 ignored", mode_o, 10'h022);
      c_mode(10'h026);
      chk("R9 bad length ignored", mode_o, 10'h022);
      c_mode(10'h223);
      chk("R9 valid word loaded", mode_o, 10'h223);
      c_open(0, 11'h3FF);
      c_read(0, 1);
      nop(7);
      chk("R8 open through 8", bank_active_o, 2'b01);
      nop(1);
      chk("R8 closed after 8", bank_active_o, 2'b00);
      c_mode(10'h022);
      chk("R9 restored", mode_o, 10'h022);
   endtask

   task automatic t_deselect();
      c_open(1, 11'h155);
      c_write(1, 1);
      step(1, 0, 0, 0, 0, 11'h023);
      chk("R2 deselect code", cmd_o, 4'd10);
      chk("R2 mode untouched", mode_o, 10'h022);
      step(1, 0, 1, 1, 0, 11'h0AA);
      chk("R2 no open", bank_active_o, 2'b10);
      nop(1);
      chk("R11 still open", bank_active_o, 2'b10);
      nop(1);
      chk("R11 closed on time", bank_active_o, 2'b00);
   endtask

   task automatic t_halt();
      c_open(0, 11'h012);
      c_read(0, 1);
      nop(1);
      c_halt();
      chk("R1 stop code", cmd_o, 4'd8);
      chk("R12 closed at stop", bank_active_o, 2'b00);
      c_open(0, 11'h013);
      c_read(0, 0);
      c_halt();
      nop(4);
      chk("R12 plain stop stays open", bank_active_o, 2'b01);
      c_close(0, 1);
   endtask

   task automatic t_pending();
      c_open(0, 11'h100);
      c_open(1, 11'h200);
      c_read(0, 1);
      c_read(1, 0);
      chk("R14 access refused", illegal_o, 1'b1);
      nop(2);
      chk("R14 pending still open", bank_active_o, 2'b11);
      nop(1);
      chk("R14 first burst closes", bank_active_o, 2'b10);
      chk("R14 other row kept", row_of(1), 11'h200);
      c_close(1, 1);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(posedge clk);
      @(negedge clk);
      t_reset();
      t_open_close();
      t_closed_access();
      t_autoclose4();
      t_mode();
      t_deselect();
      t_halt();
      t_pending();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule